// File: doc/BRIEF.md
# Configurable Serial Frame Transceiver

This block is a full-duplex asynchronous serial port. It sends and receives character frames whose shape is chosen at run time: five to nine data bits, no parity or an even or odd parity bit, and one or two stop bits. Data is sent least significant bit first, between a low start bit and high stop bits. Bit timing comes from an enable tick supplied by a baud divider outside the block. Each bit lasts 16 ticks, or 8 ticks when the faster oversampling rate is selected.

The transmit side has a single holding register in front of the shift register. Software writes a nine-bit word whenever the empty flag is high. A word written while a frame is still on the line is sent straight after that frame's last stop bit. The receive side synchronises the line and checks that a start bit is real. It settles every bit by a majority vote over the middle of the bit and stores finished frames in a two-deep queue. Each stored frame keeps its own framing, parity and overrun flags.

In multidrop use, the ninth bit tells address frames from data frames. While the filter is on, the receiver drops data frames without any trace and lets only address frames through. Three one-cycle interrupt strobes report the end of a transmission, a free holding register and a new received frame.

Top module: `serial_frame_xcvr`

## Requirements
- R1: `nbits` sets the data length (5 to 9; below 5 acts as 5, above 9 as 9). Data goes out least significant bit first and is stored in `rx_data` bits [nbits-1:0], with the unused upper bits read as 0.
- R2: The frame is a low start bit, the data bits, an optional parity bit, then one high stop bit, or two when `two_stop` is 1. The receiver checks only the first stop bit.
- R3: `par_mode` 2'b00 or 2'b01 means no parity bit, 2'b10 means even and 2'b11 means odd. The parity bit makes the count of ones over data plus parity even (even) or odd (odd). A received mismatch sets `rx_perr` on that entry.
- R4: A first stop bit received low sets `rx_ferr` on that entry, and the data is still stored.
- R5: The receive queue holds two entries. A frame that completes while both are full, with no read in the same cycle, is dropped. It sets `rx_ovr` on the oldest unread entry and raises no receive strobe.
- R6: A word already held when the current frame's last stop bit ends has its start bit begin on the very next bit period, so frames follow each other with no idle time.
- R7: `tx_wr` is taken only while `tx_empty` is 1. A write while `tx_empty` is 0 is ignored and leaves the held word unchanged.
- R8: `irq_dre` pulses for one cycle when the held word moves into the shifter. `irq_txc` pulses for one cycle when the last stop bit ends and no word is held. `irq_rxc` pulses for one cycle when a frame is stored.
- R9: With `mp_en` 1, a received frame whose ninth data bit (bit 8) is 0 is dropped with no strobe and no queue change, and a frame with bit 8 set is stored. With `mp_en` 0, every frame is stored.
- R10: A falling edge counts as a start only if the majority of the three middle samples of the start bit are low. Otherwise the receiver returns to idle and stores nothing.
- R11: Each received bit takes the 2-of-3 majority of the middle three samples, so a one-sample glitch does not change it.
- R12: `os8` 0 gives 16 ticks per bit and `os8` 1 gives 8. Both directions count time only in cycles where `tick` is 1.
- R13: After reset `txd` is 1, `tx_empty` is 1, `rx_valid` is 0 and all three strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversample enable |
| os8 | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| nbits | input | 4 | Data bits per frame, 5 to 9 |
| two_stop | input | 1 | Send two stop bits |
| par_mode | input | 2 | Parity selection |
| mp_en | input | 1 | Drop data frames (bit 8 = 0) |
| tx_data | input | 9 | Word to send |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_empty | output | 1 | Holding register is free |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Pop the oldest received entry |
| rx_data | output | 9 | Oldest received word |
| rx_valid | output | 1 | Receive queue not empty |
| rx_ferr | output | 1 | Framing error of the oldest entry |
| rx_perr | output | 1 | Parity error of the oldest entry |
| rx_ovr | output | 1 | A frame was lost after the oldest entry |
| irq_txc | output | 1 | Transmit-complete strobe |
| irq_dre | output | 1 | Holding-register-empty strobe |
| irq_rxc | output | 1 | Receive-complete strobe |

## Verification
The checker assumes that `nbits`, `par_mode`, `two_stop` and `os8` do not change while either direction has a frame in flight. It also assumes that the receive filter check is not masked by a read in the same cycle. The stimulus changes the frame settings only after the line has been idle for at least two bit periods and the receiver has stored or dropped its frame. Reads are issued only between frames. Random frames cover every data length, parity choice, stop count and oversampling rate, including a halved tick rate. Hand-made line waveforms cover bad parity, a low stop bit, queue overflow, short start pulses, single-sample glitches and address filtering.

// File: rtl/serial_frame_xcvr.sv
module serial_frame_xcvr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       os8,
  input  logic [3:0] nbits,
  input  logic       two_stop,
  input  logic [1:0] par_mode,
  input  logic       mp_en,
  input  logic [8:0] tx_data,
  input  logic       tx_wr,
  output logic       tx_empty,
  output logic       txd,
  input  logic       rxd,
  input  logic       rx_rd,
  output logic [8:0] rx_data,
  output logic       rx_valid,
  output logic       rx_ferr,
  output logic       rx_perr,
  output logic       rx_ovr,
  output logic       irq_txc,
  output logic       irq_dre,
  output logic       irq_rxc
);
  localparam int DW = 9;
  localparam int FW = DW + 4;
  localparam int EW = DW + 3;

  logic [3:0] nb, osm1, mid, pidx, sidx;
  logic       par_en, par_odd;
  assign nb      = (nbits < 4'd5) ? 4'd5 : (nbits > 4'd9) ? 4'd9 : nbits;
  assign osm1    = os8 ? 4'd7 : 4'd15;
  assign mid     = os8 ? 4'd4 : 4'd8;
  assign par_en  = par_mode[1];
  assign par_odd = par_mode[0];
  assign pidx    = nb + 4'd1;
  assign sidx    = pidx + {3'b0, par_en};

  // transmit
  logic [DW-1:0] tbuf, tdm, dmask;
  logic [FW-1:0] tsh, tfrm;
  logic [3:0]    tleft, tcnt, tlen;
  logic          tfull, tbusy, tpar, tend, ld, dre_q, txc_q;

  assign dmask = DW'((10'd1 << nb) - 10'd1);
  assign tdm   = tbuf & dmask;
  assign tpar  = (^tdm) ^ par_odd;
  assign tlen  = 4'd2 + nb + {3'b0, par_en} + {3'b0, two_stop};
  assign tend  = tbusy && tick && tcnt == osm1 && tleft == 4'd1;
  assign ld    = tfull && (!tbusy || tend);

  always_comb begin
    tfrm    = '1;
    tfrm[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (4'(i) < nb) tfrm[i+1] = tdm[i];
    if (par_en) tfrm[pidx] = tpar;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbuf <= '0; tfull <= 1'b0; tbusy <= 1'b0; tsh <= '1;
      tleft <= '0; tcnt <= '0; dre_q <= 1'b0; txc_q <= 1'b0;
    end else begin
      dre_q <= ld;
      txc_q <= tend && !tfull;
      if (tx_wr && !tfull) begin
        tbuf  <= tx_data;
        tfull <= 1'b1;
      end
      if (ld) begin
        tsh <= tfrm; tleft <= tlen; tcnt <= '0;
        tbusy <= 1'b1; tfull <= 1'b0;
      end else if (tbusy && tick) begin
        if (tcnt == osm1) begin
          tcnt  <= '0;
          tsh   <= {1'b1, tsh[FW-1:1]};
          tleft <= tleft - 4'd1;
          if (tleft == 4'd1) tbusy <= 1'b0;
        end else tcnt <= tcnt + 4'd1;
      end
    end
  end

  assign tx_empty = !tfull;
  assign txd      = !tbusy | tsh[0];
  assign irq_dre  = dre_q;
  assign irq_txc  = txc_q;

  // receive
  logic          rs1, rs2, rbusy, rpe, rdec, rdone, bitv;
  logic [3:0]    rcnt, ridx;
  logic [1:0]    vcnt;
  logic [DW-1:0] rdat;

  assign bitv  = ({1'b0, vcnt} + {2'b0, rs2}) >= 3'd2;
  assign rdec  = rbusy && tick && rcnt == mid + 4'd1;
  assign rdone = rdec && ridx == sidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs1 <= 1'b1; rs2 <= 1'b1; rbusy <= 1'b0; rpe <= 1'b0;
      rcnt <= '0; ridx <= '0; vcnt <= '0; rdat <= '0;
    end else begin
      rs1 <= rxd;
      rs2 <= rs1;
      if (!rbusy) begin
        if (tick && !rs2) begin
          rbusy <= 1'b1; rcnt <= 4'd1; ridx <= '0;
          vcnt <= '0; rdat <= '0; rpe <= 1'b0;
        end
      end else if (tick) begin
        rcnt <= (rcnt == osm1) ? 4'd0 : rcnt + 4'd1;
        if (rcnt == osm1) ridx <= ridx + 4'd1;
        if (rcnt == mid - 4'd1 || rcnt == mid) vcnt <= vcnt + {1'b0, rs2};
        if (rdec) begin
          vcnt <= '0;
          if (ridx == 4'd0) begin
            if (bitv) rbusy <= 1'b0;
          end else if (ridx <= nb) rdat[ridx - 4'd1] <= bitv;
          else if (par_en && ridx == pidx) rpe <= bitv ^ (^rdat) ^ par_odd;
          else rbusy <= 1'b0;
        end
      end
    end
  end

  // two-entry receive queue
  logic [EW-1:0] mem [2];
  logic [1:0]    cnt;
  logic          wp, rp, keep, push, pop, ovr_set, rxc_q;

  assign keep    = rdone && !(mp_en && !rdat[DW-1]);
  assign pop     = rx_rd && cnt != 2'd0;
  assign push    = keep && (cnt != 2'd2 || pop);
  assign ovr_set = keep && cnt == 2'd2 && !pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) mem[i] <= '0;
      cnt <= '0; wp <= 1'b0; rp <= 1'b0; rxc_q <= 1'b0;
    end else begin
      rxc_q <= push;
      if (push) begin
        mem[wp] <= {1'b0, rpe, ~bitv, rdat};
        wp      <= ~wp;
      end
      if (ovr_set) mem[rp][EW-1] <= 1'b1;
      if (pop) rp <= ~rp;
      cnt <= cnt + {1'b0, push} - {1'b0, pop};
    end
  end

  assign rx_data  = mem[rp][DW-1:0];
  assign rx_ferr  = mem[rp][DW];
  assign rx_perr  = mem[rp][DW+1];
  assign rx_ovr   = mem[rp][DW+2];
  assign rx_valid = cnt != 2'd0;
  assign irq_rxc  = rxc_q;
endmodule

module serial_frame_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_wr,
  input logic       tx_empty,
  input logic       txd,
  input logic       tbusy,
  input logic [8:0] tbuf,
  input logic       irq_dre,
  input logic       irq_txc,
  input logic       irq_rxc,
  input logic       rx_valid,
  input logic       rx_rd,
  input logic [1:0] cnt,
  input logic       rdone,
  input logic       mp_en,
  input logic       rdat8
);
  // R7
  held_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_empty) |=> $stable(tbuf));
  // R8
  dre_frees_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dre |-> tx_empty);
  // R8
  txc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txc |=> !irq_txc);
  // R8
  rxc_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxc |-> rx_valid);
  // R5
  queue_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd3);
  // R13
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tbusy |-> txd);
  // R9
  data_frame_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdone && mp_en && !rdat8 && !rx_rd) |=> ($stable(cnt) && !irq_rxc));
endmodule

bind serial_frame_xcvr serial_frame_xcvr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_empty(tx_empty), .txd(txd),
  .tbusy(tbusy), .tbuf(tbuf), .irq_dre(irq_dre), .irq_txc(irq_txc),
  .irq_rxc(irq_rxc), .rx_valid(rx_valid), .rx_rd(rx_rd), .cnt(cnt),
  .rdone(rdone), .mp_en(mp_en), .rdat8(rdat[8])
);

// File: tb/serial_frame_xcvr_tb.sv
module serial_frame_xcvr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic slow = 1'b0, tph = 1'b0, tick;
  always @(posedge clk) tph <= ~tph;
  assign tick = slow ? tph : 1'b1;

  logic       os8 = 0, two_stop = 0, mp_en = 0, loop = 1, drv = 1;
  logic [3:0] cfg_nb = 4'd8;
  logic [1:0] pm = 2'b00;
  logic [8:0] tx_data = '0;
  logic       tx_wr = 0, rx_rd = 0;
  logic       tx_empty, txd, rxd, rx_valid, rx_ferr, rx_perr, rx_ovr;
  logic       irq_txc, irq_dre, irq_rxc;
  logic [8:0] rx_data;

  assign rxd = loop ? txd : drv;

  serial_frame_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .os8(os8), .nbits(cfg_nb),
    .two_stop(two_stop), .par_mode(pm), .mp_en(mp_en), .tx_data(tx_data),
    .tx_wr(tx_wr), .tx_empty(tx_empty), .txd(txd), .rxd(rxd), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr),
    .rx_perr(rx_perr), .rx_ovr(rx_ovr), .irq_txc(irq_txc),
    .irq_dre(irq_dre), .irq_rxc(irq_rxc)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int n_dre = 0, n_txc = 0, n_rxc = 0, dre_prev = 0, dre_last = 0, txc_last = 0;

  always @(negedge clk) begin
    cyc++;
    if (irq_dre) begin n_dre++; dre_prev = dre_last; dre_last = cyc; end
    if (irq_txc) begin n_txc++; txc_last = cyc; end
    if (irq_rxc) n_rxc++;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bp();
    return (os8 ? 8 : 16) * (slow ? 2 : 1);
  endfunction
  function automatic int flen();
    return 2 + int'(cfg_nb) + int'(pm[1]) + int'(two_stop);
  endfunction
  function automatic logic [8:0] msk(logic [8:0] d);
    return d & 9'((10'd1 << cfg_nb) - 10'd1);
  endfunction
  function automatic logic fbit(logic [8:0] d, int k);
    if (k == 0) return 1'b0;
    if (k <= int'(cfg_nb)) return d[k-1];
    if (pm[1] && k == int'(cfg_nb) + 1) return (^msk(d)) ^ pm[0];
    return 1'b1;
  endfunction

  task automatic write_tx(logic [8:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask
  task automatic pop_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic send_rx(logic [8:0] d, bit badpar, bit badstop, int gk);
    int p = bp();
    for (int k = 0; k < flen(); k++) begin
      logic v = fbit(d, k);
      if (badpar && pm[1] && k == int'(cfg_nb) + 1) v = ~v;
      if (badstop && k == int'(cfg_nb) + 1 + int'(pm[1])) v = 1'b0;
      if (k == gk) begin
        drv = v; repeat (p/2) @(negedge clk);
        drv = ~v; @(negedge clk);
        drv = v; repeat (p - p/2 - 1) @(negedge clk);
      end else begin
        drv = v; repeat (p) @(negedge clk);
      end
    end
    drv = 1'b1;
    repeat (2*p) @(negedge clk);
  endtask

  task automatic capture_tx(logic [8:0] d);
    int p = bp();
    int t = 0;
    int cap = 0, exp = 0;
    while (txd && t < 5000) begin @(negedge clk); t++; end
    repeat (p/2) @(negedge clk);
    for (int k = 0; k < flen(); k++) begin
      cap |= int'(txd) << k;
      exp |= int'(fbit(d, k)) << k;
      repeat (p) @(negedge clk);
    end
    chk("R1/R2/R3/R12", "tx frame bits", cap, exp);
  endtask

  task automatic chk_head(string req, logic [8:0] d, bit fe, bit pe, bit ov);
    chk(req, "rx_valid", int'(rx_valid), 1);
    chk(req, "rx_data", int'(rx_data), int'(d));
    chk(req, "rx_ferr", int'(rx_ferr), int'(fe));
    chk(req, "rx_perr", int'(rx_perr), int'(pe));
    chk(req, "rx_ovr", int'(rx_ovr), int'(ov));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int dre0, txc0, rxc0, t;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    // R13 reset state
    chk("R13", "txd", int'(txd), 1);
    chk("R13", "tx_empty", int'(tx_empty), 1);
    chk("R13", "rx_valid", int'(rx_valid), 0);
    chk("R13", "strobes", int'(irq_txc) + int'(irq_dre) + int'(irq_rxc), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 R7 R8 back-to-back, ignored write, strobes
    dre0 = n_dre; txc0 = n_txc; rxc0 = n_rxc;
    write_tx(9'h0A5);
    write_tx(9'h03C);
    @(negedge clk); tx_data = 9'h0F0; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    chk("R7", "tx_empty while held", int'(tx_empty), 0);
    t = 0;
    while (n_txc == txc0 && t < 3000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
    chk("R8", "dre pulses", n_dre - dre0, 2);
    chk("R8", "txc pulses", n_txc - txc0, 1);
    chk("R8", "rxc pulses", n_rxc - rxc0, 2);
    chk("R6", "frame spacing", dre_last - dre_prev, 160);
    chk("R8", "txc timing", txc_last - dre_last, 160);
    chk_head("R6", 9'h0A5, 0, 0, 0);
    pop_rx();
    chk_head("R7", 9'h03C, 0, 0, 0);
    pop_rx();
    chk("R7", "ignored write not sent", int'(rx_valid), 0);

    // random loopback frames, R1 R2 R3 R12
    for (int it = 0; it < 24; it++) begin
      logic [8:0] d;
      int s;
      os8 = 1'($urandom % 2);
      slow = 1'($urandom % 2);
      cfg_nb = 4'(5 + $urandom % 5);
      s = $urandom % 3;
      pm = (s == 0) ? 2'b00 : (s == 1) ? 2'b10 : 2'b11;
      two_stop = 1'($urandom % 2);
      d = 9'($urandom % 512);
      repeat (4) @(negedge clk);
      write_tx(d);
      capture_tx(d);
      repeat (bp()) @(negedge clk);
      chk_head("R1/R3/R12", msk(d), 0, 0, 0);
      pop_rx();
      repeat (2*bp()) @(negedge clk);
    end

    os8 = 0; slow = 0; cfg_nb = 4'd8; pm = 2'b00; two_stop = 0; loop = 0;
    repeat (40) @(negedge clk);

    // R3 parity errors
    pm = 2'b11;
    send_rx(9'h05B, 1, 0, -1);
    chk_head("R3", 9'h05B, 0, 1, 0);
    pop_rx();
    pm = 2'b10;
    send_rx(9'h0C3, 1, 0, -1);
    chk_head("R3", 9'h0C3, 0, 1, 0);
    pop_rx();
    send_rx(9'h0C7, 0, 0, -1);
    chk_head("R3", 9'h0C7, 0, 0, 0);
    pop_rx();

    // R4 framing error
    pm = 2'b00;
    send_rx(9'h081, 0, 1, -1);
    chk_head("R4", 9'h081, 1, 0, 0);
    pop_rx();
    repeat (40) @(negedge clk);
    chk("R4", "no extra frame", int'(rx_valid), 0);

    // R5 overrun
    pm = 2'b10;
    rxc0 = n_rxc;
    send_rx(9'h011, 0, 0, -1);
    send_rx(9'h022, 0, 0, -1);
    send_rx(9'h033, 0, 0, -1);
    chk("R5", "rxc pulses", n_rxc - rxc0, 2);
    chk_head("R5", 9'h011, 0, 0, 1);
    pop_rx();
    chk_head("R5", 9'h022, 0, 0, 0);
    pop_rx();
    chk("R5", "queue empty", int'(rx_valid), 0);

    // R9 multiprocessor filter
    pm = 2'b00; cfg_nb = 4'd9; mp_en = 1;
    rxc0 = n_rxc;
    send_rx(9'h055, 0, 0, -1);
    chk("R9", "data frame dropped", int'(rx_valid), 0);
    chk("R9", "no rxc on drop", n_rxc - rxc0, 0);
    send_rx(9'h1A3, 0, 0, -1);
    chk_head("R9", 9'h1A3, 0, 0, 0);
    pop_rx();
    mp_en = 0;
    send_rx(9'h022, 0, 0, -1);
    chk_head("R9", 9'h022, 0, 0, 0);
    pop_rx();

    // R10 false start
    cfg_nb = 4'd8;
    rxc0 = n_rxc;
    drv = 0; repeat (3) @(negedge clk); drv = 1;
    repeat (3*bp()) @(negedge clk);
    chk("R10", "false start ignored", int'(rx_valid), 0);
    chk("R10", "no rxc", n_rxc - rxc0, 0);
    send_rx(9'h05A, 0, 0, -1);
    chk_head("R10", 9'h05A, 0, 0, 0);
    pop_rx();

    // R11 majority vote
    send_rx(9'h0FF, 0, 0, 3);
    chk_head("R11", 9'h0FF, 0, 0, 0);
    pop_rx();
    os8 = 1;
    send_rx(9'h000, 0, 0, 5);
    chk_head("R11", 9'h000, 0, 0, 0);
    pop_rx();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule